// File: doc/BRIEF.md
# Branch Target and Program Counter Unit

This block works out where a small controller fetches next after a program-flow instruction. From the address of the instruction that follows the jump, it produces either that address unchanged or a jump target. A target is one of two things: the sum of that address and a sign-extended 8-bit offset, or a full 16-bit address. The offset comes from the instruction or from a register. The full address comes from the instruction or from an index register pair.

A conditional relative jump picks one bit from one of two 8-bit status vectors: the condition flags or the transceiver status. It compares that bit with a wanted polarity and jumps only when they agree. The new address and a taken flag come out combinationally in the same cycle. A program counter register takes the new address on a clock edge when the execute strobe is high.

Top module: `pc_next_unit`

## Requirements
- R1: Kind code 1 (relative, immediate) gives pc_next_o = pc_seq_i + sign-extended imm8_i, with taken_o = 1.
- R2: Kind code 2 (relative, register) gives pc_next_o = pc_seq_i + sign-extended reg8_i, with taken_o = 1.
- R3: Kind code 3 (long, absolute) gives pc_next_o = abs16_i, with taken_o = 1.
- R4: Kind code 4 (long, indexed) gives pc_next_o = idx16_i, with taken_o = 1.
- R5: Kind code 5 (conditional relative) tests bit fsel_bit_i of ccr_i when fsel_src_i = 0, or of tsr_i when fsel_src_i = 1. It is taken when that bit equals fsel_pol_i (1 means jump on set, 0 means jump on clear). When taken, pc_next_o = pc_seq_i + sign-extended imm8_i and taken_o = 1.
- R6: A kind 5 jump whose tested bit differs from fsel_pol_i gives pc_next_o = pc_seq_i and taken_o = 0.
- R7: Kind codes 0, 6 and 7 are sequential: pc_next_o = pc_seq_i and taken_o = 0.
- R8: Relative sums wrap modulo 2^16 at both the top and the bottom of the address space.
- R9: On a rising clock edge with exec_i = 1, pc_q_o takes the value of pc_next_o. With exec_i = 0, pc_q_o holds its value.
- R10: While rst_n is low, pc_q_o is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe; loads the PC register |
| kind_i | input | 3 | Jump kind code |
| pc_seq_i | input | 16 | Address of the instruction after the jump |
| imm8_i | input | 8 | Immediate relative offset |
| reg8_i | input | 8 | Register relative offset |
| abs16_i | input | 16 | Absolute target from the instruction |
| idx16_i | input | 16 | Target from the index register pair |
| ccr_i | input | 8 | Condition flag vector |
| tsr_i | input | 8 | Transceiver status vector |
| fsel_src_i | input | 1 | Flag source: 0 condition flags, 1 transceiver status |
| fsel_bit_i | input | 3 | Bit index within the chosen vector |
| fsel_pol_i | input | 1 | Wanted bit value for a jump |
| pc_next_o | output | 16 | Computed next address |
| taken_o | output | 1 | High when a jump is taken |
| pc_q_o | output | 16 | Registered program counter |

## Verification
The next address and the taken flag are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs one time step later. The registered counter is due one rising edge later. The bench predicts it from the previous expected value and the strobe, then samples it shortly after that edge. Random kinds, offsets and flag selections are mixed with directed cases: wrap at 0xFFFF and at 0x0000, the unused kind codes, and both polarities on both flag sources.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [2:0] {
      K_SEQ     = 3'd0,
      K_REL_IMM = 3'd1,
      K_REL_REG = 3'd2,
      K_ABS     = 3'd3,
      K_IDX     = 3'd4,
      K_COND    = 3'd5
   } jump_kind_e;
endpackage

// File: rtl/pcu_rel_adder.sv
module pcu_rel_adder #(
   parameter int PC_W   = 16,
   parameter int OFS_W  = 8,
   parameter bit SIGNED = 1'b1
) (
   input  logic [PC_W-1:0]  base_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic [PC_W-1:0]  sum_o
);
   localparam int EXT_W = PC_W - OFS_W;
   logic [PC_W-1:0] ofs_ext;

   generate
      if (EXT_W < 1) begin : g_bad
         $error("pcu_rel_adder: PC_W must exceed OFS_W");
      end
      if (SIGNED) begin : g_sext
         assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
      end else begin : g_zext
         assign ofs_ext = {{EXT_W{1'b0}}, ofs_i};
      end
   endgenerate

   // carry out is dropped: the sum wraps modulo 2^PC_W
   assign sum_o = base_i + ofs_ext;
endmodule

// File: rtl/pcu_flag_sel.sv
module pcu_flag_sel #(
   parameter int FLAG_W = 8,
   parameter int N_SRC  = 2,
   localparam int BIT_W = $clog2(FLAG_W),
   localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC*FLAG_W-1:0] flags_i,
   input  logic [SRC_W-1:0]        src_i,
   input  logic [BIT_W-1:0]        bit_i,
   input  logic                    pol_i,
   output logic                    hit_o
);
   logic [FLAG_W-1:0] vec [N_SRC];
   logic [FLAG_W-1:0] chosen;

   generate
      if (FLAG_W < 2) begin : g_bad
         $error("pcu_flag_sel: FLAG_W must be at least 2");
      end
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         assign vec[s] = flags_i[s*FLAG_W +: FLAG_W];
      end
   endgenerate

   always_comb begin
      chosen = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (src_i == SRC_W'(s)) chosen = vec[s];
      end
   end

   assign hit_o = (chosen[bit_i] == pol_i);
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
   parameter int PC_W = 16,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [PC_W-1:0] d_i,
   output logic [PC_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RESET_PC;
      else if (load_i) q_o <= d_i;
   end

   // R9
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (q_o == $past(d_i)));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
   import pcu_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int OFS_W  = 8,
   parameter int FLAG_W = 8,
   localparam int BIT_W = $clog2(FLAG_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_i,
   input  logic [2:0]        kind_i,
   input  logic [PC_W-1:0]   pc_seq_i,
   input  logic [OFS_W-1:0]  imm8_i,
   input  logic [OFS_W-1:0]  reg8_i,
   input  logic [PC_W-1:0]   abs16_i,
   input  logic [PC_W-1:0]   idx16_i,
   input  logic [FLAG_W-1:0] ccr_i,
   input  logic [FLAG_W-1:0] tsr_i,
   input  logic              fsel_src_i,
   input  logic [BIT_W-1:0]  fsel_bit_i,
   input  logic              fsel_pol_i,
   output logic [PC_W-1:0]   pc_next_o,
   output logic              taken_o,
   output logic [PC_W-1:0]   pc_q_o
);
   logic [OFS_W-1:0] ofs_sel;
   logic [PC_W-1:0]  rel_sum;
   logic             flag_hit;
   jump_kind_e       kind;

   assign kind    = jump_kind_e'(kind_i);
   assign ofs_sel = (kind == K_REL_REG) ? reg8_i : imm8_i;

   pcu_rel_adder #(.PC_W(PC_W), .OFS_W(OFS_W), .SIGNED(1'b1)) u_add (
      .base_i(pc_seq_i), .ofs_i(ofs_sel), .sum_o(rel_sum));

   pcu_flag_sel #(.FLAG_W(FLAG_W), .N_SRC(2)) u_flag (
      .flags_i({tsr_i, ccr_i}), .src_i(fsel_src_i), .bit_i(fsel_bit_i),
      .pol_i(fsel_pol_i), .hit_o(flag_hit));

   always_comb begin
      pc_next_o = pc_seq_i;
      taken_o   = 1'b0;
      case (kind)
         K_REL_IMM, K_REL_REG: begin pc_next_o = rel_sum; taken_o = 1'b1; end
         K_ABS:  begin pc_next_o = abs16_i; taken_o = 1'b1; end
         K_IDX:  begin pc_next_o = idx16_i; taken_o = 1'b1; end
         K_COND: if (flag_hit) begin pc_next_o = rel_sum; taken_o = 1'b1; end
         default: ;
      endcase
   end

   pcu_pc_reg #(.PC_W(PC_W)) u_pc (
      .clk(clk), .rst_n(rst_n), .load_i(exec_i), .d_i(pc_next_o), .q_o(pc_q_o));

   // R6 R7
   not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_o |-> (pc_next_o == pc_seq_i));
   // R3
   abs_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd3) |-> (taken_o && pc_next_o == abs16_i));
   // R4
   idx_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd4) |-> (taken_o && pc_next_o == idx16_i));
   // R5
   cond_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd5 && taken_o) |->
         ((fsel_src_i ? tsr_i[fsel_bit_i] : ccr_i[fsel_bit_i]) == fsel_pol_i));
   // R7
   unused_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd0 || kind_i > 3'd5) |-> !taken_o);
endmodule

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [2:0]  kind_i = '0;
   logic [15:0] pc_seq_i = '0, abs16_i = '0, idx16_i = '0;
   logic [7:0]  imm8_i = '0, reg8_i = '0, ccr_i = '0, tsr_i = '0;
   logic        fsel_src_i = 1'b0, fsel_pol_i = 1'b0;
   logic [2:0]  fsel_bit_i = '0;
   logic [15:0] pc_next_o, pc_q_o;
   logic        taken_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q = '0;

   always #5 clk = ~clk;

   pc_next_unit u_pc_next_unit (.*);

   function automatic logic [15:0] sx(input logic [7:0] v);
      return {{8{v[7]}}, v};
   endfunction

   function automatic logic exp_taken();
      logic b;
      b = fsel_src_i ? tsr_i[fsel_bit_i] : ccr_i[fsel_bit_i];
      case (kind_i)
         3'd1, 3'd2, 3'd3, 3'd4: return 1'b1;
         3'd5: return b == fsel_pol_i;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] exp_next();
      if (!exp_taken()) return pc_seq_i;
      case (kind_i)
         3'd2: return pc_seq_i + sx(reg8_i);
         3'd3: return abs16_i;
         3'd4: return idx16_i;
         default: return pc_seq_i + sx(imm8_i);
      endcase
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] k);
      case (k)
         3'd1: return "R1";
         3'd2: return "R2";
         3'd3: return "R3";
         3'd4: return "R4";
         3'd5: return exp_taken() ? "R5" : "R6";
         default: return "R7";
      endcase
   endfunction

   // drive on falling edge, check combinational outputs at once, register after next rise
   task automatic step(input logic [2:0] k, input logic [15:0] pc, input logic [7:0] im,
                       input logic [7:0] rg, input logic [15:0] ab, input logic [15:0] ix,
                       input logic [7:0] cc, input logic [7:0] ts, input logic src,
                       input logic [2:0] bi, input logic pol, input logic ex, input string extra);
      logic [15:0] nx;
      @(negedge clk);
      kind_i = k; pc_seq_i = pc; imm8_i = im; reg8_i = rg; abs16_i = ab; idx16_i = ix;
      ccr_i = cc; tsr_i = ts; fsel_src_i = src; fsel_bit_i = bi; fsel_pol_i = pol; exec_i = ex;
      #1;
      nx = exp_next();
      chk({tag_of(k), extra, " next"}, pc_next_o, nx);
      chk({tag_of(k), extra, " taken"}, {15'd0, taken_o}, {15'd0, exp_taken()});
      if (ex) exp_q = nx;
      @(posedge clk); #1;
      chk("R9 pc register", pc_q_o, exp_q);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (2) @(posedge clk);
      #1 chk("R10 reset value", pc_q_o, 16'h0000);
      exec_i = 1'b1; kind_i = 3'd3; abs16_i = 16'hBEEF;
      @(posedge clk); #1 chk("R10 held in reset", pc_q_o, 16'h0000);
      @(negedge clk); rst_n = 1'b1; exec_i = 1'b0;
      // directed corners
      step(3'd1, 16'hFFF0, 8'h7F, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1, " R8 wrap top");
      chk("R8 wrap top value", pc_next_o, 16'h006F);
      step(3'd2, 16'h0010, 8'h00, 8'h80, 0, 0, 0, 0, 0, 0, 0, 1, " R8 wrap bottom");
      chk("R8 wrap bottom value", pc_next_o, 16'hFF90);
      step(3'd3, 16'h1234, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 1, "");
      step(3'd4, 16'h1234, 0, 0, 0, 16'h0000, 0, 0, 0, 0, 0, 1, "");
      step(3'd5, 16'h2000, 8'hFE, 0, 0, 0, 8'h80, 8'h00, 1'b0, 3'd7, 1'b1, 1, " ccr set");
      step(3'd5, 16'h2000, 8'hFE, 0, 0, 0, 8'h80, 8'h00, 1'b1, 3'd7, 1'b1, 1, " tsr clear");
      step(3'd5, 16'h3000, 8'h05, 0, 0, 0, 8'hFF, 8'hFE, 1'b1, 3'd0, 1'b0, 1, " jump on clear");
      step(3'd5, 16'h3000, 8'h05, 0, 0, 0, 8'h01, 8'hFF, 1'b0, 3'd0, 1'b0, 1, " ccr not clear");
      step(3'd6, 16'h4444, 8'h10, 8'h10, 16'h1, 16'h2, 8'hFF, 8'hFF, 0, 0, 1, 1, " code 6");
      step(3'd7, 16'h5555, 8'h10, 8'h10, 16'h1, 16'h2, 8'hFF, 8'hFF, 0, 0, 1, 1, " code 7");
      step(3'd0, 16'h6666, 8'h10, 8'h10, 16'h1, 16'h2, 8'hFF, 8'hFF, 0, 0, 1, 0, " hold");
      step(3'd3, 16'h0000, 0, 0, 16'hA5A5, 0, 0, 0, 0, 0, 0, 0, " no exec");
      // random mix
      for (int i = 0; i < 400; i++) begin
         step(3'($urandom_range(0, 7)), 16'($urandom), 8'($urandom), 8'($urandom),
              16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
              3'($urandom), 1'($urandom), 1'($urandom), " random");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule